// File: doc/BRIEF.md
# Gated 13-Bit Timer/Counter

This block is one timer/counter channel. Its count is 13 bits wide and is held in two byte registers. The high byte supplies the upper 8 bits of the count, and the low five bits of the low byte supply the lower part. Software loads both bytes and the control settings through a single write port.

Each increment needs a tick, and the source of that tick is chosen by the control settings. In timer mode the tick is either every system clock or one clock in twelve. In counter mode the tick is a falling edge on an external count pin. A run bit must be set for any counting to happen. When the gate bit is set, counting also needs a high level on an external gate pin, which lets software measure how long a pulse stays high.

When the count wraps from its maximum to zero, a sticky overflow flag is raised. The flag stays set until an acknowledge pulse from the interrupt logic clears it.

Top module: `tmr13_gated`

## Requirements
- R1: After reset, the 13-bit count reads zero and the overflow flag is low. All control bits are zero, so no counting takes place until software writes the control byte.
- R2: The count value is {count_hi, count_lo[4:0]}. Each increment adds one to this 13-bit value, and a carry out of low-byte bit 4 goes into the high byte.
- R3: Bits 7..5 of the low byte take no part in counting. A value written there does not change the 13-bit count sequence, and the value read back from those bits is not specified.
- R4: An increment that takes the count from 0x1FFF to 0x0000 sets ovf_flag at the same edge. The flag then stays set while counting continues.
- R5: An irq_ack high at a clock edge clears ovf_flag at that edge. If a wrap happens at the same edge, the flag is set instead.
- R6: Counting is enabled only when run = 1 and (gate = 0 or the synchronized gate_pin = 1). gate_pin passes through a two-flop synchronizer. With the gate bit clear, gate_pin has no effect.
- R7: In timer mode with the undivided-clock bit set, the count increases by one at every clock edge. This starts at the first edge after the edge that writes run = 1.
- R8: In timer mode with the undivided-clock bit clear, the count increases once every 12 clocks. The first increment comes at the 12th edge after the edge that writes run = 1, because the divider is held at its start while run = 0.
- R9: In counter mode, cnt_pin passes through a two-flop synchronizer and each falling edge adds exactly one count. Rising edges do not count, a steady level does not count, and the undivided-clock bit is ignored.
- R10: While run = 0, the loaded count holds its value. Setting run does not clear or change the count.
- R11: A write to either count byte in the same cycle as an increment takes priority over it. The count takes the written value without the increment, and no overflow is flagged in that cycle.
- R12: wr_addr 0 writes the low byte, 1 writes the high byte, and 2 writes the control byte. In the control byte, bit 0 is run, bit 1 is gate enable, bit 2 selects the external count pin, and bit 3 selects the undivided clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| cnt_pin | input | 1 | External count input (asynchronous) |
| gate_pin | input | 1 | External gate input (asynchronous) |
| irq_ack | input | 1 | Interrupt taken, clears the overflow flag |
| count_hi | output | 8 | High byte of the count |
| count_lo | output | 8 | Low byte of the count (bits 4..0 active) |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Both count bytes are registered outputs, so a wrong increment decision shows on count_hi and count_lo one edge after it happens. A wrong prescaler phase shows up within twelve cycles as a first timer-mode increment that arrives early or late. A synchronizer or edge detector of the wrong depth shows as a gate or pin response that is shifted by a cycle, or as a pulse count that is wrong. A flag that is lost or set by mistake is visible at the wrap edge or at the edge that carries the acknowledge.

// File: rtl/tmr13_pkg.sv
package tmr13_pkg;

  typedef enum logic [1:0] {
    ADDR_LO   = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;

  // Packed so that run sits at bit 0 of the control byte
  typedef struct packed {
    logic fast;
    logic ext;
    logic gate;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr13_sync.sv
module tmr13_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/tmr13_ctrl.sv
module tmr13_ctrl
  import tmr13_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CTRL_W-1:0] wr_bits,
  output ctrl_t             ctrl_q,
  output logic              wr_lo,
  output logic              wr_hi
);

  reg_addr_e addr;

  always_comb begin
    addr  = reg_addr_e'(wr_addr);
    wr_lo = wr_en && (addr == ADDR_LO);
    wr_hi = wr_en && (addr == ADDR_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && (addr == ADDR_CTRL)) begin
      ctrl_q <= ctrl_t'(wr_bits);
    end
  end

endmodule

// File: rtl/tmr13_tick.sv
module tmr13_tick #(
  parameter int PRESCALE = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ext,
  input  logic fast,
  input  logic pin_s,
  output logic tick
);

  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic pin_prev;
  logic fall;
  logic div_tick;

  always_ff @(posedge clk) begin
    if (rst) pin_prev <= 1'b0;
    else     pin_prev <= pin_s;
  end

  assign fall = pin_prev & ~pin_s;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PS_W-1:0] ps_q;
      logic            ps_end;

      assign ps_end = (ps_q == PS_W'(PRESCALE - 1));

      always_ff @(posedge clk) begin
        if (rst || !run)  ps_q <= '0;
        else if (ps_end)  ps_q <= '0;
        else              ps_q <= ps_q + PS_W'(1);
      end

      assign div_tick = ps_end & run;
    end else begin : g_nodiv
      assign div_tick = run;
    end
  endgenerate

  always_comb begin
    if (ext)       tick = fall;
    else if (fast) tick = 1'b1;
    else           tick = div_tick;
  end

endmodule

// File: rtl/tmr13_core.sv
module tmr13_core #(
  parameter int BYTE_W = 8,
  parameter int LO_ACT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              irq_ack,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic              flag
);

  localparam int CNT_W = BYTE_W + LO_ACT;

  logic [CNT_W-1:0] cnt13;
  logic [CNT_W:0]   sum;
  logic             any_wr;
  logic             step;
  logic             roll;

  always_comb begin
    cnt13  = {cnt_hi, cnt_lo[LO_ACT-1:0]};
    sum    = {1'b0, cnt13} + (CNT_W+1)'(1);
    any_wr = wr_lo | wr_hi;
    step   = inc & ~any_wr;
    roll   = step & sum[CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_hi <= '0;
      cnt_lo <= '0;
    end else if (any_wr) begin
      if (wr_lo) cnt_lo <= wr_data;
      if (wr_hi) cnt_hi <= wr_data;
    end else if (step) begin
      cnt_hi               <= sum[CNT_W-1:LO_ACT];
      cnt_lo[LO_ACT-1:0]   <= sum[LO_ACT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (roll)    flag <= 1'b1;
    else if (irq_ack) flag <= 1'b0;
  end

endmodule

// File: rtl/tmr13_gated.sv
module tmr13_gated
  import tmr13_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int LO_ACT      = 5,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              irq_ack,
  output logic [BYTE_W-1:0] count_hi,
  output logic [BYTE_W-1:0] count_lo,
  output logic              ovf_flag
);

  ctrl_t ctrl_w;
  logic  wr_lo_w;
  logic  wr_hi_w;
  logic  gate_s;
  logic  pin_s;
  logic  tick_w;
  logic  cnt_en_w;
  logic  inc_w;

  tmr13_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bits (wr_data[CTRL_W-1:0]),
    .ctrl_q  (ctrl_w),
    .wr_lo   (wr_lo_w),
    .wr_hi   (wr_hi_w)
  );

  tmr13_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({gate_pin, cnt_pin}),
    .q   ({gate_s, pin_s})
  );

  tmr13_tick #(
    .PRESCALE (PRESCALE)
  ) u_tick (
    .clk   (clk),
    .rst   (rst),
    .run   (ctrl_w.run),
    .ext   (ctrl_w.ext),
    .fast  (ctrl_w.fast),
    .pin_s (pin_s),
    .tick  (tick_w)
  );

  assign cnt_en_w = ctrl_w.run & (~ctrl_w.gate | gate_s);
  assign inc_w    = cnt_en_w & tick_w;

  tmr13_core #(
    .BYTE_W (BYTE_W),
    .LO_ACT (LO_ACT)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .inc     (inc_w),
    .wr_lo   (wr_lo_w),
    .wr_hi   (wr_hi_w),
    .wr_data (wr_data),
    .irq_ack (irq_ack),
    .cnt_hi  (count_hi),
    .cnt_lo  (count_lo),
    .flag    (ovf_flag)
  );

endmodule

// File: rtl/tmr13_gated_chk.sv
module tmr13_gated_chk #(
  parameter int BYTE_W = 8,
  parameter int LO_ACT = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic              irq_ack,
  input logic [BYTE_W-1:0] count_hi,
  input logic [BYTE_W-1:0] count_lo,
  input logic              ovf_flag,
  input logic              cnt_en_w,
  input logic              inc_w
);

  localparam int CNT_W = BYTE_W + LO_ACT;

  logic [CNT_W-1:0] val;
  logic             at_max;
  logic             wr_cnt;
  logic             wrap_now;
  logic             rst_q;

  assign val      = {count_hi, count_lo[LO_ACT-1:0]};
  assign at_max   = &val;
  assign wr_cnt   = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1);
  assign wrap_now = inc_w && !wr_cnt && at_max;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      AST_RESET_STATE: assert (val == '0 && !ovf_flag); // R1
    end
  end

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (inc_w && !wr_cnt) |=> (val == $past(val) + CNT_W'(1))); // R2

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    wrap_now |=> (ovf_flag && val == '0)); // R4

  AST_FLAG_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(wrap_now)); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !wrap_now) |=> !ovf_flag); // R5

  AST_WRAP_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && wrap_now) |=> ovf_flag); // R5

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en_w && !wr_cnt) |=> $stable(val)); // R6

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=> (count_lo == $past(wr_data))); // R11

  AST_WRITE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt && !ovf_flag && !wrap_now) |=> !ovf_flag); // R11

endmodule

bind tmr13_gated tmr13_gated_chk #(
  .BYTE_W (BYTE_W),
  .LO_ACT (LO_ACT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .irq_ack  (irq_ack),
  .count_hi (count_hi),
  .count_lo (count_lo),
  .ovf_flag (ovf_flag),
  .cnt_en_w (cnt_en_w),
  .inc_w    (inc_w)
);

// File: tb/tmr13_gated_test.sv
`timescale 1ns/1ps
module tmr13_gated_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       cnt_pin = 1'b0;
  logic       gate_pin = 1'b0;
  logic       irq_ack = 1'b0;
  logic [7:0] count_hi;
  logic [7:0] count_lo;
  logic       ovf_flag;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [12:0] qv[$];
  bit          qf[$];
  string       qt[$];

  always #10 clk = ~clk;

  tmr13_gated uut (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cnt_pin  (cnt_pin),
    .gate_pin (gate_pin),
    .irq_ack  (irq_ack),
    .count_hi (count_hi),
    .count_lo (count_lo),
    .ovf_flag (ovf_flag)
  );

  function automatic logic [12:0] mk(input logic [7:0] h, input logic [4:0] l);
    return {h, l};
  endfunction

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  // expected state after the next rising edge; consumes one cycle
  task automatic chk(input logic [12:0] v, input bit f, input string t);
    qv.push_back(v); qf.push_back(f); qt.push_back(t);
    cyc();
  endtask

  // monitor: pops one expectation per cycle, 5 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (qv.size() > 0) begin
        logic [12:0] ev;
        bit          ef;
        string       et;
        ev = qv.pop_front(); ef = qf.pop_front(); et = qt.pop_front();
        n_vec++;
        if ({count_hi, count_lo[4:0]} !== ev || ovf_flag !== ef) begin
          n_bad++;
          $display("FAIL %s: got count=%h flag=%b, expected count=%h flag=%b",
                   et, {count_hi, count_lo[4:0]}, ovf_flag, ev, ef);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    // R1 reset state and no counting
    chk(13'h0, 0, "R1 reset state");
    cyc(5);
    chk(13'h0, 0, "R1 idle after reset");

    // R10 load while stopped, R12 address map
    wr(2'd0, 8'h1E);
    wr(2'd1, 8'h12);
    chk(mk(8'h12, 5'h1E), 0, "R10 R12 load bytes");
    cyc(4);
    chk(mk(8'h12, 5'h1E), 0, "R10 hold while stopped");

    // R7 fast timer, R2 carry, R10 run keeps count, R6 gate bit off ignores pin
    wr(2'd2, 8'h09);
    chk(mk(8'h12, 5'h1F), 0, "R10 R7 first step keeps loaded value");
    chk(mk(8'h13, 5'h00), 0, "R2 carry into high byte");
    cyc(7);
    chk(mk(8'h12, 5'h1E) + 13'd10, 0, "R7 R6 one per clock");
    wr(2'd2, 8'h00);
    chk(mk(8'h12, 5'h1E) + 13'd11, 0, "R10 stop holds");
    cyc(3);
    chk(mk(8'h12, 5'h1E) + 13'd11, 0, "R10 stopped hold");

    // R3 upper low-byte bits do not count
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h09);
    chk(mk(8'h01, 5'h00), 0, "R3 carry from bit 4");
    chk(mk(8'h01, 5'h01), 0, "R3 next step");
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hE0);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h09);
    chk(13'd1, 0, "R3 upper bits ignored a");
    chk(13'd2, 0, "R3 upper bits ignored b");
    wr(2'd2, 8'h00);

    // R4 wrap, R5 acknowledge
    wr(2'd0, 8'h1E);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h09);
    chk(13'h1FFF, 0, "R4 at max");
    chk(13'h0000, 1, "R4 wrap sets flag");
    chk(13'h0001, 1, "R4 flag sticky");
    irq_ack = 1'b1;
    chk(13'h0002, 0, "R5 ack clears");
    irq_ack = 1'b0;
    chk(13'h0003, 0, "R5 stays clear");
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h1F);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h09);
    irq_ack = 1'b1;
    chk(13'h0000, 1, "R5 wrap beats ack");
    chk(13'h0001, 0, "R5 later ack clears");
    irq_ack = 1'b0;
    wr(2'd2, 8'h00);

    // R11 write beats increment
    wr(2'd0, 8'h1F);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h09);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h05;
    chk(mk(8'hFF, 5'h05), 0, "R11 low write wins, no wrap");
    wr_en = 1'b0;
    chk(mk(8'hFF, 5'h06), 0, "R11 counting resumes");
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h40;
    chk(mk(8'h40, 5'h06), 0, "R11 high write cancels step");
    wr_en = 1'b0;
    chk(mk(8'h40, 5'h07), 0, "R11 after high write");
    wr(2'd2, 8'h00);

    // R8 divide by twelve
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
    cyc(10);
    chk(13'd0, 0, "R8 no step before 12th edge");
    chk(13'd1, 0, "R8 step at 12th edge");
    cyc(10);
    chk(13'd1, 0, "R8 no step at 23rd edge");
    chk(13'd2, 0, "R8 step at 24th edge");
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h01);
    cyc(10);
    chk(13'd2, 0, "R8 restart no early step");
    chk(13'd3, 0, "R8 prescaler restarts from zero");
    wr(2'd2, 8'h00);

    // R6 gate pin
    wr(2'd2, 8'h0B);
    chk(13'd3, 0, "R6 gated off");
    cyc(4);
    chk(13'd3, 0, "R6 gated off hold");
    gate_pin = 1'b1;
    chk(13'd3, 0, "R6 sync stage 1");
    chk(13'd3, 0, "R6 sync stage 2");
    chk(13'd4, 0, "R6 gate opens");
    cyc(4);
    chk(13'd9, 0, "R6 counting while open");
    gate_pin = 1'b0;
    cyc(4);
    chk(13'd11, 0, "R6 gate closes after sync");
    wr(2'd2, 8'h00);

    // R9 external falling edges
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    cnt_pin = 1'b1;
    cyc(4);
    wr(2'd2, 8'h0D);
    chk(13'd0, 0, "R9 steady pin no count");
    cyc(6);
    chk(13'd0, 0, "R9 fast bit ignored");
    for (int i = 0; i < 5; i++) begin
      cnt_pin = 1'b0;
      cyc(3);
      cnt_pin = 1'b1;
      cyc(3);
    end
    cyc(3);
    chk(13'd5, 0, "R9 five falling edges");

    cyc(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule